// File: doc/BRIEF.md
# Nested interrupt priority controller

This block picks which pending interrupt request to hand to the core next, and decides whether that request may interrupt the handler already running. Every source has an eight-bit-class priority value, where a smaller number means more urgent. A run-time group split divides that value into two parts. The upper bits form the preemption level, which controls nesting. The lower bits form the sub-priority, which only orders requests that wait side by side. The controller keeps a small stack of the preemption levels of the handlers that are running, so that it always knows which level is current and which level is restored when a handler returns.

The core side is a plain control handshake rather than a data stream, so no valid/ready back-pressure applies.
- The core pulses `ctx_saved` when a context save that was requested has finished and the handler starts.
- The core pulses `hnd_return` when the innermost handler finishes.

For each take, the controller states whether a new context save is needed (`take_save`). It also reports whether the take continues straight from a finishing handler (`take_chain`), or whether it replaces a target whose context save was still in progress (`take_swap`). Only simple set and clear of the pending latches is provided. Context saving and vector fetch are left to the core.

Top module: `nest_prio_ctrl`

## Requirements
- R1: After reset nothing is pending, no handler is active (`act_valid`=0, `nest_depth`=0), `saving` is 0 and `take` is 0.
- R2: A high `req_set[i]` makes source i pending at the next clock edge. A high `req_clr[i]` removes it. When both are high in the same cycle, the set wins.
- R3: Among pending sources the winner is the smallest priority value. This is equivalent to comparing preemption level first and then sub-priority, because the preemption bits are the upper bits. Equal values go to the lowest source index.
- R4: A source's preemption level is its priority value with the low `grp_split` bits forced to 0. A `grp_split` above PRIO_W acts as PRIO_W, and then every source shares one level.
- R5: With no handler active and no save in progress, any pending source is taken in the same cycle with `take_save`=1. The controller then shows `saving`=1.
- R6: While a handler is active, a pending source is taken only if its level is numerically strictly below the current `act_level`. Equal or higher values wait.
- R7: The taken source's pending bit clears at the clock edge that ends the take cycle, unless `req_set` sets it again in that same cycle.
- R8: While `saving` is 1, `ctx_saved` pushes the target's level. `act_level` then equals that level, `nest_depth` rises by one and `saving` falls.
- R9: While `saving` is 1 and `ctx_saved` is 0, a winner whose level is strictly below the target's level is taken with `take_swap`=1 and `take_save`=0. It becomes the new target, and the displaced source is pending again at the next edge.
- R10: On `hnd_return` with no tail chain, the top level is popped. `nest_depth` falls by one and `act_level` shows the level underneath.
- R11: On `hnd_return`, a winner whose level is strictly below the level underneath (or any winner when the stack holds one entry) is taken in that same cycle with `take_chain`=1 and `take_save`=0. It replaces the top entry, so `nest_depth` is unchanged.
- R12: `hnd_return` has no effect while `saving` is 1 or while no handler is active.
- R13: Each take carries exactly one of `take_save`, `take_chain` and `take_swap`. The level stack never holds more than 2**PRIO_W entries, and each entry is strictly more urgent than the one below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | NUM_SRC | Per-source pending set |
| req_clr | input | NUM_SRC | Per-source pending clear |
| prio_flat | input | NUM_SRC*PRIO_W | Priority of source i at bits [i*PRIO_W +: PRIO_W] |
| grp_split | input | $clog2(PRIO_W+1) | Number of low bits that form the sub-priority |
| ctx_saved | input | 1 | Requested context save has finished, handler starts |
| hnd_return | input | 1 | Innermost handler has finished |
| take | output | 1 | A source is selected this cycle |
| take_id | output | $clog2(NUM_SRC) | Index of the selected source |
| take_save | output | 1 | Take needs a fresh context save |
| take_chain | output | 1 | Take chains directly from a finishing handler |
| take_swap | output | 1 | Take replaces the target of a save in progress |
| saving | output | 1 | A context save is in progress |
| act_valid | output | 1 | At least one handler is active |
| act_level | output | PRIO_W | Preemption level of the innermost handler |
| nest_depth | output | $clog2(2**PRIO_W+1) | Number of active handlers |
| pending | output | NUM_SRC | Pending bits |

## Verification
The arbitration sweep runs many pending masks and priority patterns. It catches a design that picks the highest index on equal values, or one that compares sub-priority before level. The nesting sweep covers every pair of priorities under every split. It exposes a design that nests on an equal level, or that masks the wrong bits, and would therefore preempt where it must wait. Directed sequences cover three behaviours:
- Tail chaining: a faulty design would ask for a needless save or would push instead of replacing the top entry.
- Late arrival: a faulty design would lose the displaced request or request a second save.
- Returns during a save: a faulty design would pop a level that was never entered.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic {
    PH_RUN  = 1'b0,
    PH_SAVE = 1'b1
  } npc_phase_e;
endpackage

// File: rtl/npc_pend.sv
module npc_pend #(
  parameter int NS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  input  logic [NS-1:0] take_clr_i,
  input  logic [NS-1:0] repend_i,
  output logic [NS-1:0] pend_o
);
  logic [NS-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i & ~take_clr_i) | set_i | repend_i;
  end

  assign pend_o = pend_q;

  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_clr_i) |=> ((pend_q & $past(take_clr_i) & ~$past(set_i) & ~$past(repend_i)) == '0)); // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R2
endmodule

// File: rtl/npc_pick.sv
module npc_pick #(
  parameter int NS = 32,
  parameter int PW = 8,
  parameter int IW = 5
) (
  input  logic [NS-1:0]    pend_i,
  input  logic [NS*PW-1:0] prio_i,
  output logic             win_vld_o,
  output logic [IW-1:0]    win_id_o,
  output logic [PW-1:0]    win_prio_o
);
  always_comb begin
    win_vld_o  = 1'b0;
    win_id_o   = '0;
    win_prio_o = '1;
    for (int i = 0; i < NS; i++) begin
      if (pend_i[i] && (!win_vld_o || (prio_i[i*PW +: PW] < win_prio_o))) begin
        win_vld_o  = 1'b1;
        win_id_o   = IW'(i);
        win_prio_o = prio_i[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/npc_levels.sv
module npc_levels #(
  parameter int PW    = 8,
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          repl_i,
  input  logic [PW-1:0] val_i,
  output logic [PW-1:0] top_o,
  output logic [PW-1:0] below_o,
  output logic          below_vld_o,
  output logic [CW-1:0] depth_o
);
  logic [PW-1:0] lvl [DEPTH];
  logic [DEPTH-1:0] wr_en;
  logic [CW-1:0] depth_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_wr
    assign wr_en[g] = (push_i && (depth_q == CW'(g))) ||
                      (repl_i && (depth_q == CW'(g + 1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) lvl[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) if (wr_en[i]) lvl[i] <= val_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      depth_q <= '0;
    else if (push_i) depth_q <= depth_q + CW'(1);
    else if (pop_i)  depth_q <= depth_q - CW'(1);
  end

  always_comb begin
    top_o   = '0;
    below_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (depth_q == CW'(i + 1)) top_o   = lvl[i];
      if (depth_q == CW'(i + 2)) below_o = lvl[i];
    end
  end

  assign below_vld_o = (depth_q > CW'(1));
  assign depth_o     = depth_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (depth_q < CW'(DEPTH))); // R13
  AST_PUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && (depth_q != '0)) |-> (val_i < top_o)); // R13
  AST_REPL_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (repl_i && below_vld_o) |-> (val_i < below_o)); // R11
  AST_POP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> (depth_q == $past(depth_q) - CW'(1))); // R10
  AST_REPL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    repl_i |=> $stable(depth_q)); // R11
endmodule

// File: rtl/nest_prio_ctrl.sv
module nest_prio_ctrl
  import npc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8,
  localparam int IW     = $clog2(NUM_SRC),
  localparam int SW     = $clog2(PRIO_W + 1),
  localparam int DEPTH  = 1 << PRIO_W,
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        req_set,
  input  logic [NUM_SRC-1:0]        req_clr,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  input  logic [SW-1:0]             grp_split,
  input  logic                      ctx_saved,
  input  logic                      hnd_return,
  output logic                      take,
  output logic [IW-1:0]             take_id,
  output logic                      take_save,
  output logic                      take_chain,
  output logic                      take_swap,
  output logic                      saving,
  output logic                      act_valid,
  output logic [PRIO_W-1:0]         act_level,
  output logic [CW-1:0]             nest_depth,
  output logic [NUM_SRC-1:0]        pending
);
  npc_phase_e          phase_q, phase_d;
  logic [IW-1:0]       tgt_id_q, tgt_id_d;
  logic [PRIO_W-1:0]   tgt_lvl_q, tgt_lvl_d;

  logic [SW-1:0]       split_c;
  logic [PRIO_W-1:0]   premask;
  logic                win_vld;
  logic [IW-1:0]       win_id;
  logic [PRIO_W-1:0]   win_prio, win_lvl;

  logic                push, pop, repl;
  logic [PRIO_W-1:0]   stk_val, top_lvl, below_lvl;
  logic                below_vld;
  logic [CW-1:0]       depth;
  logic [NUM_SRC-1:0]  take_clr, repend;

  // preemption mask from the group split
  always_comb begin
    split_c = (grp_split > SW'(PRIO_W)) ? SW'(PRIO_W) : grp_split;
    for (int b = 0; b < PRIO_W; b++) premask[b] = (b >= int'(split_c));
  end

  npc_pend #(.NS(NUM_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(req_set), .clr_i(req_clr),
    .take_clr_i(take_clr), .repend_i(repend), .pend_o(pending)
  );

  npc_pick #(.NS(NUM_SRC), .PW(PRIO_W), .IW(IW)) u_pick (
    .pend_i(pending), .prio_i(prio_flat),
    .win_vld_o(win_vld), .win_id_o(win_id), .win_prio_o(win_prio)
  );

  assign win_lvl = win_prio & premask;

  npc_levels #(.PW(PRIO_W), .DEPTH(DEPTH), .CW(CW)) u_lvl (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .repl_i(repl),
    .val_i(stk_val), .top_o(top_lvl), .below_o(below_lvl),
    .below_vld_o(below_vld), .depth_o(depth)
  );

  assign act_valid  = (depth != '0);
  assign act_level  = top_lvl;
  assign nest_depth = depth;
  assign saving     = (phase_q == PH_SAVE);
  assign take_id    = win_id;

  always_comb begin
    phase_d    = phase_q;
    tgt_id_d   = tgt_id_q;
    tgt_lvl_d  = tgt_lvl_q;
    take       = 1'b0;
    take_save  = 1'b0;
    take_chain = 1'b0;
    take_swap  = 1'b0;
    push       = 1'b0;
    pop        = 1'b0;
    repl       = 1'b0;
    stk_val    = tgt_lvl_q;
    repend     = '0;
    if (phase_q == PH_SAVE) begin
      if (ctx_saved) begin
        push    = 1'b1;
        phase_d = PH_RUN;
      end else if (win_vld && (win_lvl < tgt_lvl_q)) begin
        take             = 1'b1;
        take_swap        = 1'b1;
        repend[tgt_id_q] = 1'b1;
        tgt_id_d         = win_id;
        tgt_lvl_d        = win_lvl;
      end
    end else if (hnd_return && act_valid) begin
      if (win_vld && (!below_vld || (win_lvl < below_lvl))) begin
        take       = 1'b1;
        take_chain = 1'b1;
        repl       = 1'b1;
        stk_val    = win_lvl;
      end else begin
        pop = 1'b1;
      end
    end else if (win_vld && (!act_valid || (win_lvl < top_lvl))) begin
      take      = 1'b1;
      take_save = 1'b1;
      phase_d   = PH_SAVE;
      tgt_id_d  = win_id;
      tgt_lvl_d = win_lvl;
    end
  end

  always_comb begin
    take_clr = '0;
    if (take) take_clr[win_id] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_RUN;
      tgt_id_q  <= '0;
      tgt_lvl_q <= '0;
    end else begin
      phase_q   <= phase_d;
      tgt_id_q  <= tgt_id_d;
      tgt_lvl_q <= tgt_lvl_d;
    end
  end

  AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending[take_id]); // R3
  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($countones({take_save, take_chain, take_swap}) == 1)); // R13
  AST_SWAP_IN_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_swap |-> saving); // R9
  AST_SAVE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(saving) |-> $past(take_save)); // R8
  AST_RET_IN_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (saving && hnd_return && !ctx_saved) |=> $stable(nest_depth)); // R12
endmodule

// File: tb/sim_nest_prio_ctrl.sv
module sim_nest_prio_ctrl;
  localparam int NS = 4;
  localparam int PW = 3;
  localparam int SW = $clog2(PW + 1);
  localparam int CW = $clog2((1 << PW) + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] req_set = '0, req_clr = '0;
  logic [NS*PW-1:0] prio_flat = '0;
  logic [SW-1:0] grp_split = '0;
  logic ctx_saved = 1'b0, hnd_return = 1'b0;
  logic take, take_save, take_chain, take_swap, saving, act_valid;
  logic [1:0] take_id;
  logic [PW-1:0] act_level;
  logic [CW-1:0] nest_depth;
  logic [NS-1:0] pending;

  int n_run = 0, n_fail = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  nest_prio_ctrl #(.NUM_SRC(NS), .PRIO_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
    .prio_flat(prio_flat), .grp_split(grp_split), .ctx_saved(ctx_saved),
    .hnd_return(hnd_return), .take(take), .take_id(take_id),
    .take_save(take_save), .take_chain(take_chain), .take_swap(take_swap),
    .saving(saving), .act_valid(act_valid), .act_level(act_level),
    .nest_depth(nest_depth), .pending(pending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lv(input int x, input int s);
    if (s >= PW) return 0;
    return (x >> s) << s;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_set = '0; req_clr = '0;
    ctx_saved = 1'b0; hnd_return = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_prio(input int i, input int v);
    prio_flat[i*PW +: PW] = PW'(v);
  endtask

  task automatic pulse(input int mask);
    @(negedge clk); req_set = NS'(mask);
    @(negedge clk); req_set = '0;
    #1;
  endtask

  task automatic save_done();
    @(negedge clk); ctx_saved = 1'b1;
    @(negedge clk); ctx_saved = 1'b0;
    #1;
  endtask

  task automatic ret();
    @(negedge clk); hnd_return = 1'b1;
    @(negedge clk); hnd_return = 1'b0;
    #1;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
  end

  initial begin
    // R1 reset state
    do_reset();
    #1;
    check(pending == 0 && !act_valid && nest_depth == 0 && !saving && !take,
          "R1 reset", int'(pending), 0);

    // R3 R5 R7 arbitration sweep from idle
    for (int mask = 1; mask < 16; mask++) begin
      for (int t = 0; t < 40; t++) begin
        int best, bid;
        do_reset();
        grp_split = SW'(t % 4);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        prio_flat = lfsr[11:0];
        best = 99; bid = 0;
        for (int i = 0; i < NS; i++)
          if (mask[i] && int'(prio_flat[i*PW +: PW]) < best) begin
            best = int'(prio_flat[i*PW +: PW]); bid = i;
          end
        pulse(mask);
        check(take && take_save && int'(take_id) == bid, "R3 winner", int'(take_id), bid);
        @(negedge clk); #1;
        check(int'(pending) == (mask & ~(1 << bid)), "R7 pend clear", int'(pending),
              mask & ~(1 << bid));
        check(saving, "R5 saving", int'(saving), 1);
      end
    end

    // R4 R6 R8 nesting sweep over every split and priority pair
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          do_reset();
          grp_split = SW'(s);
          set_prio(0, a); set_prio(1, b);
          pulse(1);
          save_done();
          check(act_valid && int'(act_level) == lv(a, s) && nest_depth == 1,
                "R8 push level", int'(act_level), lv(a, s));
          pulse(2);
          check(take == (lv(b, s) < lv(a, s)), "R6 preempt", int'(take),
                int'(lv(b, s) < lv(a, s)));
          if (take) check(take_save && !take_chain, "R4 preempt save", int'(take_save), 1);
        end
      end
    end

    // R11 tail chain with equal level, R10 pop to empty
    do_reset();
    grp_split = '0;
    set_prio(0, 2); set_prio(1, 2);
    pulse(1); save_done();
    pulse(2);
    check(!take, "R6 equal waits", int'(take), 0);
    @(negedge clk); hnd_return = 1'b1; #1;
    check(take && take_chain && !take_save && take_id == 1, "R11 tail chain",
          int'(take_chain), 1);
    @(negedge clk); hnd_return = 1'b0; #1;
    check(nest_depth == 1 && act_level == 2 && pending == 0 && !saving,
          "R11 depth kept", int'(nest_depth), 1);
    ret();
    check(nest_depth == 0 && !act_valid, "R10 pop empty", int'(nest_depth), 0);
    ret();
    check(nest_depth == 0 && !take, "R12 return idle", int'(nest_depth), 0);

    // R10 three-deep nesting, restore, tail chain under a lower level
    do_reset();
    set_prio(0, 6); set_prio(1, 4); set_prio(2, 1); set_prio(3, 5);
    pulse(1); save_done();
    pulse(2); save_done();
    pulse(4);
    check(take && take_save, "R6 nest third", int'(take), 1);
    save_done();
    check(nest_depth == 3 && act_level == 1, "R8 depth3", int'(act_level), 1);
    ret();
    check(nest_depth == 2 && act_level == 4, "R10 restore", int'(act_level), 4);
    pulse(8);
    check(!take, "R6 lower waits", int'(take), 0);
    @(negedge clk); hnd_return = 1'b1; #1;
    check(take && take_chain && take_id == 3, "R11 chain below", int'(take_id), 3);
    @(negedge clk); hnd_return = 1'b0; #1;
    check(nest_depth == 2 && act_level == 5, "R11 replace top", int'(act_level), 5);
    ret();
    check(nest_depth == 1 && act_level == 6, "R10 restore base", int'(act_level), 6);

    // R9 late arrival
    do_reset();
    set_prio(0, 6); set_prio(1, 1); set_prio(2, 6);
    pulse(1);
    @(negedge clk); req_set = 4'b0100;
    @(negedge clk); req_set = '0; #1;
    check(!take, "R9 equal no swap", int'(take), 0);
    @(negedge clk); req_set = 4'b0010;
    @(negedge clk); req_set = '0; #1;
    check(take && take_swap && !take_save && take_id == 1, "R9 swap", int'(take_swap), 1);
    @(negedge clk); #1;
    check(pending == 4'b0101 && saving, "R9 repend", int'(pending), 5);
    save_done();
    check(nest_depth == 1 && act_level == 1, "R9 new target", int'(act_level), 1);

    // R12 return during save
    do_reset();
    set_prio(0, 3);
    pulse(1);
    @(negedge clk); hnd_return = 1'b1; #1;
    check(!take, "R12 no take", int'(take), 0);
    @(negedge clk); hnd_return = 1'b0; #1;
    check(saving && nest_depth == 0, "R12 ignored", int'(nest_depth), 0);

    // R2 set and clear while a handler blocks taking
    do_reset();
    set_prio(0, 0); set_prio(1, 5);
    pulse(1); save_done();
    pulse(2);
    check(pending == 4'b0010 && !take, "R2 set", int'(pending), 2);
    @(negedge clk); req_clr = 4'b0010;
    @(negedge clk); req_clr = '0; #1;
    check(pending == 0, "R2 clear", int'(pending), 0);
    @(negedge clk); req_clr = 4'b0010; req_set = 4'b0010;
    @(negedge clk); req_clr = '0; req_set = '0; #1;
    check(pending == 4'b0010, "R2 set wins", int'(pending), 2);

    // R4 split at maximum: one shared level, no nesting
    do_reset();
    grp_split = SW'(PW);
    set_prio(0, 7); set_prio(1, 0);
    pulse(1); save_done();
    check(act_level == 0, "R4 full split level", int'(act_level), 0);
    pulse(2);
    check(!take, "R4 no nest", int'(take), 0);
    check(nest_depth <= 8, "R13 depth bound", int'(nest_depth), 1);

    summary();
  end
endmodule